// File: doc/BRIEF.md
# Epoch Checkpoint and Lane Repair Controller

This block runs speculative execution in fixed-length epochs for a small multi-lane processor. It keeps a working register file that the core writes freely, plus a shadow copy that holds the last validated state. While an epoch runs, each lane's built-in self-test checker works only in cycles when that lane is idle. The checker reports completion, and a fault flag with it. The controller remembers which lanes have finished clean in the current epoch.

When the programmed epoch length runs out and every enabled lane has reported a clean finish, the controller commits: the working file is copied into the shadow. If any lane is still testing, the epoch is stretched until the last enabled lane finishes. A fault from an enabled lane ends the epoch at once. The working file is rolled back to the shadow, the faulty lane is removed from the enable mask for good, and a sticky degraded flag tells the system controller that a defect was found. If the last enabled lane fails, the controller stops in a terminal state, raises a fatal error, and freezes the register state.

Top module: `epoch_guard`

## Requirements
- R1: While reset is held, laneEn is all ones, status is 2'b00 (running), commitStb, restoreStb, degradedFlag and fatalErr are 0, testRun is 0 when laneIdle is 0, and every register reads 0.
- R2: With all enabled lanes reporting testDone and no fault, commitStb is a one-cycle pulse. Its first pulse appears after the epochLen-th rising edge following reset release, and later pulses follow every epochLen edges.
- R3: If an enabled lane has not reported testDone by the epochLen-th edge of an epoch, no commit occurs and status reads 2'b01 (extended). The commit is issued at the edge where the last missing testDone is sampled, and status returns to 2'b00.
- R4: At a commit the working registers are copied into the shadow, so a later rollback restores exactly the values present at that commit.
- R5: A fault is testDone and testFail both high on an enabled lane. It produces a restoreStb pulse in the following cycle, at whose end every register equals the shadow. A write issued during that restore cycle is discarded, and a new full-length epoch starts from that cycle.
- R6: On a fault, each faulting lane's bit in laneEn clears at the same edge as restoreStb rises and never sets again.
- R7: degradedFlag rises together with the first fault's restore and stays high.
- R8: A testFail or testDone from a lane whose laneEn bit is 0 is ignored: it causes no rollback, and the lane's done report is not needed for a commit.
- R9: testRun for a lane is high exactly when that lane is idle, enabled, has not yet reported done in the current epoch, and the controller is not in the failed state.
- R10: A fault that would leave no lane enabled moves status to 2'b10 and raises fatalErr, both permanently, with laneEn at 0. No restore or commit strobe is issued, and later register writes are ignored.
- R11: A write with wrEn high is visible on rdData for that address from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| epochLen | input | CNT_W | Epoch length in cycles (0 acts as 1) |
| wrEn | input | 1 | Working register write enable |
| wrAddr | input | AW | Write address |
| wrData | input | DW | Write data |
| rdAddr | input | AW | Read address |
| rdData | output | DW | Working register read data |
| laneIdle | input | LANES | Per-lane idle indication |
| testDone | input | LANES | Per-lane self-test completion |
| testFail | input | LANES | Per-lane fault flag, valid with testDone |
| testRun | output | LANES | Per-lane permission to run a test cycle |
| commitStb | output | 1 | Epoch committed (one cycle) |
| restoreStb | output | 1 | Rollback to checkpoint (one cycle) |
| laneEn | output | LANES | Lane enable mask |
| status | output | 2 | 00 running, 01 extended, 10 failed |
| degradedFlag | output | 1 | Sticky first-defect notification |
| fatalErr | output | 1 | All lanes lost |

## Verification
The bench builds the block with four lanes, sixteen 32-bit registers and an 8-bit epoch counter, and drives an epoch length of 8. With epochs that short, a single run of under a hundred cycles covers several commit boundaries, one stretched epoch, two rollbacks with different lane subsets, and the loss of the last lane. The four-lane mask makes it possible to fault lanes one at a time, to fault several lanes at once, and to fault a lane that is already disabled, so the mask updates and the ignore rule can each be observed.

// File: rtl/epoch_guard_pkg.sv
package epoch_guard_pkg;

  // Controller phase; the encoding is visible on the status port.
  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_EXTEND = 2'b01,
    ST_DEAD   = 2'b10
  } eg_state_e;

  // Strobes from control to the register datapath.
  typedef struct packed {
    logic commit;
    logic restore;
    logic freeze;
  } eg_strobe_t;

endpackage

// File: rtl/epoch_guard_ctrl.sv
module epoch_guard_ctrl
  import epoch_guard_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] epochLen,
  input  logic [LANES-1:0] laneIdle,
  input  logic [LANES-1:0] testDone,
  input  logic [LANES-1:0] testFail,
  output logic [LANES-1:0] testRun,
  output logic [LANES-1:0] laneEn,
  output eg_strobe_t       strb,
  output logic [1:0]       status,
  output logic             degradedFlag,
  output logic             fatalErr
);

  eg_state_e        stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD, lastCnt;
  logic [LANES-1:0] seenQ, seenD, enQ, enD;
  logic [LANES-1:0] faultHit, laneOk, survivors;
  logic             commitQ, commitD, restoreQ, restoreD;
  logic             degQ, degD;
  logic             allDone, anyFault, expired;

  assign lastCnt = (epochLen == '0) ? '0 : epochLen - 1'b1;
  assign expired = (cntQ >= lastCnt);

  // Per-lane bookkeeping: fault qualification, completion, test permission.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign faultHit[g] = testDone[g] & testFail[g] & enQ[g];
    assign laneOk[g]   = seenQ[g] | testDone[g] | ~enQ[g];
    assign testRun[g]  = laneIdle[g] & enQ[g] & ~seenQ[g] & (stateQ != ST_DEAD);
  end

  assign allDone   = &laneOk;
  assign anyFault  = |faultHit;
  assign survivors = enQ & ~faultHit;

  always_comb begin
    stateD   = stateQ;
    cntD     = cntQ;
    seenD    = seenQ | (testDone & enQ);
    enD      = enQ;
    degD     = degQ;
    commitD  = 1'b0;
    restoreD = 1'b0;
    case (stateQ)
      ST_RUN, ST_EXTEND: begin
        if (anyFault) begin
          enD   = survivors;
          degD  = 1'b1;
          seenD = '0;
          cntD  = '0;
          if (survivors == '0) begin
            stateD = ST_DEAD;
          end else begin
            restoreD = 1'b1;
            stateD   = ST_RUN;
          end
        end else if (stateQ == ST_EXTEND || expired) begin
          if (allDone) begin
            commitD = 1'b1;
            cntD    = '0;
            seenD   = '0;
            stateD  = ST_RUN;
          end else begin
            stateD = ST_EXTEND;
          end
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      default: begin
        seenD = seenQ;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_RUN;
      cntQ     <= '0;
      seenQ    <= '0;
      enQ      <= '1;
      degQ     <= 1'b0;
      commitQ  <= 1'b0;
      restoreQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      cntQ     <= cntD;
      seenQ    <= seenD;
      enQ      <= enD;
      degQ     <= degD;
      commitQ  <= commitD;
      restoreQ <= restoreD;
    end
  end

  assign strb.commit  = commitQ;
  assign strb.restore = restoreQ;
  assign strb.freeze  = (stateQ == ST_DEAD);
  assign laneEn       = enQ;
  assign status       = stateQ;
  assign degradedFlag = degQ;
  assign fatalErr     = (stateQ == ST_DEAD);

endmodule

// File: rtl/epoch_guard_regs.sv
module epoch_guard_regs
  import epoch_guard_pkg::*;
#(
  parameter int REGS = 16,
  parameter int DW   = 32,
  localparam int AW  = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  eg_strobe_t    strb,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] work   [REGS];
  logic [DW-1:0] shadow [REGS];

  // Working file: rollback wins over a core write in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REGS; i++) work[i] <= '0;
    end else if (strb.restore) begin
      work <= shadow;
    end else if (wrEn && !strb.freeze) begin
      work[wrAddr] <= wrData;
    end
  end

  // Shadow file: whole-array capture at the commit edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REGS; i++) shadow[i] <= '0;
    end else if (strb.commit) begin
      shadow <= work;
    end
  end

  assign rdData = work[rdAddr];

endmodule

// File: rtl/epoch_guard.sv
module epoch_guard
  import epoch_guard_pkg::*;
#(
  parameter int LANES = 4,
  parameter int REGS  = 16,
  parameter int DW    = 32,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] epochLen,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic [AW-1:0]    rdAddr,
  output logic [DW-1:0]    rdData,
  input  logic [LANES-1:0] laneIdle,
  input  logic [LANES-1:0] testDone,
  input  logic [LANES-1:0] testFail,
  output logic [LANES-1:0] testRun,
  output logic             commitStb,
  output logic             restoreStb,
  output logic [LANES-1:0] laneEn,
  output logic [1:0]       status,
  output logic             degradedFlag,
  output logic             fatalErr
);

  eg_strobe_t strb;

  epoch_guard_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .epochLen(epochLen),
    .laneIdle(laneIdle), .testDone(testDone), .testFail(testFail),
    .testRun(testRun), .laneEn(laneEn), .strb(strb), .status(status),
    .degradedFlag(degradedFlag), .fatalErr(fatalErr)
  );

  epoch_guard_regs #(.REGS(REGS), .DW(DW)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  assign commitStb  = strb.commit;
  assign restoreStb = strb.restore;

endmodule

// File: rtl/epoch_guard_chk.sv
module epoch_guard_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             commitStb,
  input logic             restoreStb,
  input logic [LANES-1:0] laneEn,
  input logic [LANES-1:0] testRun,
  input logic             degradedFlag,
  input logic             fatalErr
);

  // R2 / R5: a boundary is either a commit or a rollback, never both.
  p_one_boundary_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(commitStb && restoreStb));

  // R6: a cleared lane bit never comes back.
  p_mask_monotone_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((laneEn & ~$past(laneEn)) == '0));

  // R6: every rollback coincides with at least one lane being dropped.
  p_restore_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(restoreStb) |-> (laneEn != $past(laneEn)));

  // R7: the defect notification is sticky.
  p_notify_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    degradedFlag |=> degradedFlag);

  // R9: no test permission on a disabled lane.
  p_run_enabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((testRun & ~laneEn) == '0));

  // R10: failed state is terminal and quiet.
  p_fatal_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    fatalErr |-> (laneEn == '0 && !commitStb && !restoreStb && testRun == '0));

  p_fatal_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    fatalErr |=> fatalErr);

endmodule

bind epoch_guard epoch_guard_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .commitStb(commitStb), .restoreStb(restoreStb),
  .laneEn(laneEn), .testRun(testRun), .degradedFlag(degradedFlag),
  .fatalErr(fatalErr)
);

// File: tb/sim_epoch_guard.sv
`timescale 1ns/1ps
module sim_epoch_guard;

  localparam int LANES = 4;
  localparam int REGS  = 16;
  localparam int DW    = 32;
  localparam int CNT_W = 8;
  localparam int AW    = $clog2(REGS);
  localparam int LEN   = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] epochLen = CNT_W'(LEN);
  logic             wrEn = 1'b0;
  logic [AW-1:0]    wrAddr = '0;
  logic [DW-1:0]    wrData = '0;
  logic [AW-1:0]    rdAddr = '0;
  logic [DW-1:0]    rdData;
  logic [LANES-1:0] laneIdle = '0;
  logic [LANES-1:0] testDone = '1;
  logic [LANES-1:0] testFail = '0;
  logic [LANES-1:0] testRun, laneEn;
  logic             commitStb, restoreStb, degradedFlag, fatalErr;
  logic [1:0]       status;

  always #2.5 clk = ~clk;

  epoch_guard #(.LANES(LANES), .REGS(REGS), .DW(DW), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .epochLen(epochLen),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .laneIdle(laneIdle), .testDone(testDone), .testFail(testFail),
    .testRun(testRun), .commitStb(commitStb), .restoreStb(restoreStb),
    .laneEn(laneEn), .status(status), .degradedFlag(degradedFlag),
    .fatalErr(fatalErr)
  );

  typedef struct { bit isCommit; int edgeAt; } ev_t;
  ev_t expQ[$];

  int nChecks = 0;
  int nFails  = 0;
  int edgeNo  = 0;
  bit finished = 0;
  logic [DW-1:0] gWork [REGS];
  logic [DW-1:0] gShadow [REGS];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic toEdge(input int k);
    while (edgeNo < k) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input bit keep);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    if (keep) gWork[a] = d;
  endtask

  // Monitor: pops expected boundary events and compares kind and edge.
  initial begin
    forever begin
      @(posedge clk);
      edgeNo++;
      #1;
      if (rstN && (commitStb || restoreStb)) begin
        if (commitStb && restoreStb) begin
          chk("R2 both strobes", 1, 0);
        end else if (expQ.size() == 0) begin
          chk(commitStb ? "R2 unexpected commit" : "R8 unexpected restore", edgeNo, 0);
        end else begin
          ev_t e;
          e = expQ.pop_front();
          chk(e.isCommit ? "R2 commit kind" : "R5 restore kind", commitStb, e.isCommit);
          chk(e.isCommit ? "R2 commit edge" : "R5 restore edge", edgeNo, e.edgeAt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int e0;
    for (int i = 0; i < REGS; i++) begin gWork[i] = '0; gShadow[i] = '0; end
    laneIdle = '1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 laneEn", laneEn, 4'hF);
    chk("R1 status", status, 2'b00);
    chk("R1 strobes", {commitStb, restoreStb}, 0);
    chk("R1 flags", {degradedFlag, fatalErr}, 0);
    chk("R1 rdData", rdData, 0);
    laneIdle = '0;
    #1 chk("R1 testRun", testRun, 0);
    rstN = 1'b1;
    e0 = edgeNo + 1;

    // Phase 1: plain epoch with writes, commit at e0+7 (R2, R11)
    expQ.push_back('{1'b1, e0 + LEN - 1});
    for (int i = 0; i < 4; i++) begin
      toEdge(e0 + i);
      wr(i, 32'h1111_0000 + DW'(i), 1);
    end
    toEdge(e0 + 4);
    wrEn = 1'b0; rdAddr = 1;
    #1 chk("R11 read reg1", rdData, gWork[1]);
    rdAddr = 3;
    #1 chk("R11 read reg3", rdData, gWork[3]);
    toEdge(e0 + 7);
    for (int i = 0; i < REGS; i++) gShadow[i] = gWork[i];
    chk("R2 status run", status, 2'b00);
    chk("R7 no notify yet", degradedFlag, 0);

    // Phase 2: overwrite, fault lane 2 at e0+11 (R4, R5, R6, R7)
    toEdge(e0 + 8);  wr(0, 32'hBBBB_0000, 1);
    toEdge(e0 + 9);  wr(1, 32'hBBBB_0001, 1);
    toEdge(e0 + 10); wrEn = 1'b0; testFail = 4'b0100;
    expQ.push_back('{1'b0, e0 + 11});
    toEdge(e0 + 11);
    chk("R6 lane2 dropped", laneEn, 4'b1011);
    chk("R7 notify", degradedFlag, 1);
    chk("R10 not fatal", fatalErr, 0);
    wr(5, 32'hDEAD_0005, 0);  // lands in restore cycle, discarded (R5)
    for (int i = 0; i < REGS; i++) gWork[i] = gShadow[i];
    expQ.push_back('{1'b1, e0 + 19});
    expQ.push_back('{1'b1, e0 + 27});
    toEdge(e0 + 12);
    wrEn = 1'b0;
    testDone = 4'b1011;  // lane 2 never done, fail held: ignored (R8)
    for (int r = 0; r < REGS; r++) begin
      toEdge(e0 + 12 + r);
      rdAddr = AW'(r);
      #1 chk($sformatf("R4 R5 restored reg%0d", r), rdData, gShadow[r]);
    end

    // Phase 3: lane 3 late, epoch stretched (R3, R9)
    testDone = 4'b0011;
    toEdge(e0 + 35);
    chk("R3 extended status", status, 2'b01);
    laneIdle = 4'b1001;
    #1 chk("R9 testRun pending lane", testRun, 4'b1000);
    laneIdle = 4'b0000;
    #1 chk("R9 testRun not idle", testRun, 4'b0000);
    toEdge(e0 + 39);
    testDone = 4'b1011;
    expQ.push_back('{1'b1, e0 + 40});
    toEdge(e0 + 40);
    chk("R3 back to run", status, 2'b00);
    laneIdle = 4'b1111;
    #1 chk("R9 testRun fresh epoch", testRun, 4'b1011);
    laneIdle = 4'b0000;

    // Phase 4: drop lanes 0,1 together, then last lane (R6, R8, R10)
    toEdge(e0 + 42);
    testFail = 4'b0111;
    expQ.push_back('{1'b0, e0 + 43});
    toEdge(e0 + 43);
    testFail = 4'b0000;
    chk("R6 lanes 0,1 dropped", laneEn, 4'b1000);
    chk("R10 still alive", fatalErr, 0);
    for (int i = 0; i < REGS; i++) gWork[i] = gShadow[i];
    toEdge(e0 + 44);
    wr(3, 32'hCCCC_0003, 1);
    toEdge(e0 + 45);
    wrEn = 1'b0; testFail = 4'b1000;
    toEdge(e0 + 46);
    testFail = 4'b0000;
    chk("R10 failed status", status, 2'b10);
    chk("R10 fatal", fatalErr, 1);
    chk("R10 mask empty", laneEn, 4'b0000);
    wr(4, 32'hDEAD_0004, 0);
    toEdge(e0 + 47);
    wrEn = 1'b0; rdAddr = 4;
    #1 chk("R10 write ignored", rdData, gWork[4]);
    rdAddr = 3;
    #1 chk("R10 no rollback", rdData, 32'hCCCC_0003);
    laneIdle = 4'b1111;
    #1 chk("R9 R10 no test when failed", testRun, 4'b0000);
    toEdge(e0 + 70);
    chk("R10 stays failed", {status, fatalErr}, {2'b10, 1'b1});
    chk("R7 notify held", degradedFlag, 1);
    chk("R2 R5 all events seen", expQ.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule